// File: doc/BRIEF.md
# Prefix-Sequenced Add-With-Carry Unit

This block is the byte-serial decode and execute slice of a sixteen-register, 16-bit processor core. It takes instruction bytes one per accepted cycle. Prefix bytes select the alternate opcode mode and choose which registers act as source and destination. Those choices persist until an add-with-carry instruction uses them. The add has two forms, chosen by the alternate-mode prefix in force. In the register form the second addend comes from any of the sixteen registers. In the immediate form it is a 4-bit constant taken from the opcode byte and zero-extended.

After each add the unit writes the 16-bit sum to the selected destination register and updates four flags. It then returns every piece of prefix state to the default, with source and destination both set to R0. Fetch timing is modelled as a busy window whose length depends on whether the instruction came from cache. Bytes that arrive during that window are dropped. A combinational read port exposes any register, so that a surrounding pipeline or a bench can observe the register file.

Top module: `prefix_adc_unit`

## Requirements
- R1: Asynchronous reset. While `rst_ni` is low, register Rk holds (k * 0x1111) mod 2^16, `flags_o` is 0, `busy_o` is 0, `alt_o` is 0 and `with_o` is 0. Source and destination are both R0.
- R2: In ALT1 state (`alt_o` = 2'b01), an accepted byte 0x5n writes source + Rn + carry to the destination register. `rd_data_o` shows the new value from the cycle after that byte's edge.
- R3: In ALT3 state (`alt_o` = 2'b11), an accepted byte 0x5n writes source + n + carry to the destination. Here n is zero-extended to 16 bits.
- R4: If no register-select byte has arrived since reset or since the last add, source and destination are both R0.
- R5: Byte 0x2n makes Rn both source and destination and sets `with_o`. Byte 0xBn makes Rn the source only. Byte 0x1n makes Rn the destination only. The latest byte wins for each field, and the choice persists until an add executes.
- R6: `flags_o` is {overflow, sign, carry, zero} in bits 3..0 and is loaded on each add. Carry is the carry out of bit 15. Sign is bit 15 of the sum. Zero is set when the sum is 0x0000. Overflow is set when both addends share a sign and the sum's sign differs from it.
- R7: In the cycle after an add, `alt_o` is 0 and `with_o` is 0, and source and destination are back to R0.
- R8: An add raises `busy_o` for exactly 2 cycles after its edge if `cache_hit_i` was high at that edge, and for 6 cycles otherwise. Prefix bytes do not raise `busy_o`.
- R9: While `busy_o` is high, incoming bytes are dropped. They change no register, no flag and no prefix state.
- R10: Byte 0x3D sets `alt_o` to 2'b01, byte 0x3E to 2'b10 and byte 0x3F to 2'b11, replacing the earlier mode. None of these bytes changes the register selection.
- R11: A byte that matches none of the above, or a 0x5n byte in ALT0 or ALT2 state, changes no register, no flag and no prefix state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_valid_i | input | 1 | An instruction byte is presented |
| byte_i | input | 8 | Instruction byte |
| cache_hit_i | input | 1 | The current instruction was fetched from cache |
| rd_idx_i | input | 4 | Register index for the read port |
| rd_data_o | output | 16 | Contents of register `rd_idx_i` |
| flags_o | output | 4 | {overflow, sign, carry, zero} |
| busy_o | output | 1 | Execution window active; bytes are dropped |
| alt_o | output | 2 | Alternate-mode state, {alt2, alt1} |
| with_o | output | 1 | Set-both prefix in force |

## Verification
The add is exercised in four ways. Plain chains with no prefix show that both operands default to R0. Chains that use the set-both, source-only and destination-only prefixes in different orders show that each prefix affects only its own field and that the latest one wins. Register-form and immediate-form adds are run on the same operands, which separates the two second-addend paths. Carry-in chains, the 0x8888 + 0x8888 case and the 0xFFFF + 1 case set the carry, overflow and zero flags separately. Bytes are also sent during the busy window, along with unknown bytes and 0x5n bytes in ALT0 and ALT2, to show that dropped and ignored bytes change nothing. A long weighted random byte stream then mixes all of these cases.

// File: rtl/padc_pkg.sv
package padc_pkg;
  localparam int XLEN = 16;
  localparam int NREG = 16;
  localparam int RIDX = $clog2(NREG);

  typedef logic [XLEN-1:0] word_t;
  typedef logic [RIDX-1:0] ridx_t;

  typedef struct packed {
    logic  alt1;
    logic  alt2;
    logic  with_b;
    ridx_t src;
    ridx_t dst;
  } pfx_t;

  typedef struct packed {
    logic ov;
    logic s;
    logic cy;
    logic z;
  } flags_t;

  localparam pfx_t PFX_IDLE = '0;

  localparam logic [7:0] OP_ALT1 = 8'h3D;
  localparam logic [7:0] OP_ALT2 = 8'h3E;
  localparam logic [7:0] OP_ALT3 = 8'h3F;
  localparam logic [3:0] HI_WITH = 4'h2;
  localparam logic [3:0] HI_FROM = 4'hB;
  localparam logic [3:0] HI_TO   = 4'h1;
  localparam logic [3:0] HI_ADC  = 4'h5;
endpackage

// File: rtl/padc_prefix.sv
module padc_prefix
  import padc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       take_i,
  input  logic [7:0] byte_i,
  output pfx_t       pfx_o,
  output logic       exec_o,
  output logic       imm_o
);
  pfx_t pfx_q, pfx_d;
  logic [3:0] hi, lo;

  assign hi     = byte_i[7:4];
  assign lo     = byte_i[3:0];
  assign exec_o = take_i && (hi == HI_ADC) && pfx_q.alt1;
  assign imm_o  = pfx_q.alt2;
  assign pfx_o  = pfx_q;

  always_comb begin
    pfx_d = pfx_q;
    if (exec_o) begin
      pfx_d = PFX_IDLE;
    end else if (take_i) begin
      if (byte_i == OP_ALT1) begin
        pfx_d.alt1 = 1'b1; pfx_d.alt2 = 1'b0;
      end else if (byte_i == OP_ALT2) begin
        pfx_d.alt1 = 1'b0; pfx_d.alt2 = 1'b1;
      end else if (byte_i == OP_ALT3) begin
        pfx_d.alt1 = 1'b1; pfx_d.alt2 = 1'b1;
      end else begin
        case (hi)
          HI_WITH: begin
            pfx_d.src    = ridx_t'(lo);
            pfx_d.dst    = ridx_t'(lo);
            pfx_d.with_b = 1'b1;
          end
          HI_FROM: pfx_d.src = ridx_t'(lo);
          HI_TO:   pfx_d.dst = ridx_t'(lo);
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pfx_q <= PFX_IDLE;
    else         pfx_q <= pfx_d;
  end

  assert_prefix_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o |=> (pfx_q == PFX_IDLE));

  assert_dropped_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_i |=> (pfx_q == $past(pfx_q)));
endmodule

// File: rtl/padc_regfile.sv
module padc_regfile #(
  parameter int NREG       = 16,
  parameter int XLEN       = 16,
  parameter int RESET_STEP = 'h1111,
  localparam int RIDX      = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [RIDX-1:0] widx_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [RIDX-1:0] a_idx_i,
  input  logic [RIDX-1:0] b_idx_i,
  input  logic [RIDX-1:0] r_idx_i,
  output logic [XLEN-1:0] a_o,
  output logic [XLEN-1:0] b_o,
  output logic [XLEN-1:0] r_o
);
  logic [XLEN-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [XLEN-1:0] RV = XLEN'(i * RESET_STEP);
    logic [XLEN-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         q <= RV;
      else if (we_i && widx_i == RIDX'(i)) q <= wdata_i;
    end
    assign regs[i] = q;
  end

  assign a_o = regs[a_idx_i];
  assign b_o = regs[b_idx_i];
  assign r_o = regs[r_idx_i];

  assert_write_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (regs[$past(widx_i)] == $past(wdata_i)));
endmodule

// File: rtl/padc_alu.sv
module padc_alu
  import padc_pkg::*;
(
  input  word_t  a_i,
  input  word_t  b_i,
  input  logic   cin_i,
  output word_t  sum_o,
  output flags_t fl_o
);
  logic [XLEN:0] wide;

  assign wide     = {1'b0, a_i} + {1'b0, b_i} + {{XLEN{1'b0}}, cin_i};
  assign sum_o    = wide[XLEN-1:0];
  assign fl_o.cy  = wide[XLEN];
  assign fl_o.s   = wide[XLEN-1];
  assign fl_o.z   = (wide[XLEN-1:0] == '0);
  assign fl_o.ov  = (a_i[XLEN-1] == b_i[XLEN-1]) && (wide[XLEN-1] != a_i[XLEN-1]);
endmodule

// File: rtl/padc_busy.sv
module padc_busy #(
  parameter int SLOW_CYC = 6,
  parameter int FAST_CYC = 2,
  localparam int CW      = $clog2(SLOW_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic hit_i,
  output logic busy_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (start_i)      cnt_q <= hit_i ? CW'(FAST_CYC) : CW'(SLOW_CYC);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  assert_busy_starts_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);

  assert_busy_ends_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CW'(1) && !start_i) |=> !busy_o);
endmodule

// File: rtl/prefix_adc_unit.sv
module prefix_adc_unit
  import padc_pkg::*;
#(
  parameter int SLOW_CYC   = 6,
  parameter int FAST_CYC   = 2,
  parameter int RESET_STEP = 'h1111
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        byte_valid_i,
  input  logic [7:0]  byte_i,
  input  logic        cache_hit_i,
  input  logic [3:0]  rd_idx_i,
  output logic [15:0] rd_data_o,
  output logic [3:0]  flags_o,
  output logic        busy_o,
  output logic [1:0]  alt_o,
  output logic        with_o
);
  logic   take, exec, imm;
  pfx_t   pfx;
  word_t  a_w, rb_w, b_w, sum_w;
  flags_t alu_fl, fl_q;

  assign take = byte_valid_i && !busy_o;

  padc_prefix u_prefix (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .take_i (take),
    .byte_i (byte_i),
    .pfx_o  (pfx),
    .exec_o (exec),
    .imm_o  (imm)
  );

  padc_regfile #(.NREG(NREG), .XLEN(XLEN), .RESET_STEP(RESET_STEP)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (exec),
    .widx_i  (pfx.dst),
    .wdata_i (sum_w),
    .a_idx_i (pfx.src),
    .b_idx_i (ridx_t'(byte_i[3:0])),
    .r_idx_i (ridx_t'(rd_idx_i)),
    .a_o     (a_w),
    .b_o     (rb_w),
    .r_o     (rd_data_o)
  );

  assign b_w = imm ? word_t'(byte_i[3:0]) : rb_w;

  padc_alu u_alu (
    .a_i   (a_w),
    .b_i   (b_w),
    .cin_i (fl_q.cy),
    .sum_o (sum_w),
    .fl_o  (alu_fl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   fl_q <= '0;
    else if (exec) fl_q <= alu_fl;
  end

  padc_busy #(.SLOW_CYC(SLOW_CYC), .FAST_CYC(FAST_CYC)) u_busy (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (exec),
    .hit_i   (cache_hit_i),
    .busy_o  (busy_o)
  );

  assign flags_o = fl_q;
  assign alt_o   = {pfx.alt2, pfx.alt1};
  assign with_o  = pfx.with_b;

  assert_no_exec_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !exec);

  assert_flags_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec |=> (flags_o == $past(flags_o)));

  assert_ov_sign_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec && alu_fl.ov) |-> (a_w[XLEN-1] == b_w[XLEN-1]));
endmodule

// File: tb/prefix_adc_unit_bench.sv
`timescale 1ns/1ps
module prefix_adc_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        byte_valid_i = 1'b0;
  logic [7:0]  byte_i = 8'h00;
  logic        cache_hit_i = 1'b0;
  logic [3:0]  rd_idx_i = 4'h0;
  logic [15:0] rd_data_o;
  logic [3:0]  flags_o;
  logic        busy_o;
  logic [1:0]  alt_o;
  logic        with_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // behavioural reference state
  int m_reg [16];
  int m_ov, m_s, m_cy, m_z;
  int m_alt1, m_alt2, m_with, m_src, m_dst, m_busy;
  int rd_rot = 0;

  always #4 clk_i = ~clk_i;

  prefix_adc_unit u_prefix_adc_unit (
    .clk_i, .rst_ni, .byte_valid_i, .byte_i, .cache_hit_i,
    .rd_idx_i, .rd_data_o, .flags_o, .busy_o, .alt_o, .with_o
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < 16; k++) m_reg[k] = (k * 'h1111) & 'hFFFF;
    m_ov = 0; m_s = 0; m_cy = 0; m_z = 0;
    m_alt1 = 0; m_alt2 = 0; m_with = 0; m_src = 0; m_dst = 0; m_busy = 0;
  endtask

  task automatic model_edge(bit v, int b, bit hit);
    int hi, lo, a, bb, sum, res;
    bit take;
    take = v && (m_busy == 0);
    if (m_busy > 0) m_busy--;
    if (!take) return;
    hi = (b >> 4) & 15;
    lo = b & 15;
    if (hi == 5 && m_alt1 == 1) begin
      a   = m_reg[m_src];
      bb  = (m_alt2 == 1) ? lo : m_reg[lo];
      sum = a + bb + m_cy;
      res = sum & 'hFFFF;
      m_cy = (sum >> 16) & 1;
      m_s  = (res >> 15) & 1;
      m_z  = (res == 0);
      m_ov = (((a ^ bb) & 'h8000) == 0) && (((a ^ res) & 'h8000) != 0);
      m_reg[m_dst] = res;
      m_alt1 = 0; m_alt2 = 0; m_with = 0; m_src = 0; m_dst = 0;
      m_busy = hit ? 2 : 6;
    end else if (b == 'h3D) begin m_alt1 = 1; m_alt2 = 0; end
    else if (b == 'h3E)     begin m_alt1 = 0; m_alt2 = 1; end
    else if (b == 'h3F)     begin m_alt1 = 1; m_alt2 = 1; end
    else if (hi == 2)       begin m_src = lo; m_dst = lo; m_with = 1; end
    else if (hi == 'hB)     m_src = lo;
    else if (hi == 1)       m_dst = lo;
  endtask

  task automatic compare(string req);
    chk(req, "rd_data", int'(rd_data_o), m_reg[rd_idx_i]);
    chk("R6", "flags", int'(flags_o), (m_ov << 3) | (m_s << 2) | (m_cy << 1) | m_z);
    chk("R8", "busy", int'(busy_o), int'(m_busy != 0));
    chk("R10", "alt", int'(alt_o), (m_alt2 << 1) | m_alt1);
    chk("R7", "with", int'(with_o), m_with);
  endtask

  // one cycle: drive at negedge, model at posedge, compare at next negedge
  task automatic step(bit v, int b, bit hit, string req);
    byte_valid_i = v;
    byte_i       = b[7:0];
    cache_hit_i  = hit;
    rd_idx_i     = rd_rot[3:0];
    rd_rot++;
    @(posedge clk_i);
    model_edge(v, b, hit);
    @(negedge clk_i);
    compare(req);
  endtask

  task automatic send(int b, bit hit, string req);
    step(1'b1, b, hit, req);
  endtask

  task automatic idle_sweep(string req);
    for (int k = 0; k < 16; k++) step(1'b0, 0, 1'b0, req);
  endtask

  initial begin
    model_reset();
    #20;
    @(negedge clk_i);
    for (int k = 0; k < 16; k++) begin
      rd_idx_i = k[3:0];
      #1;
      chk("R1", "reset reg", int'(rd_data_o), m_reg[k]);
    end
    chk("R1", "reset flags", int'(flags_o), 0);
    chk("R1", "reset busy", int'(busy_o), 0);
    chk("R1", "reset alt", int'(alt_o), 0);
    chk("R1", "reset with", int'(with_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R4 defaults, R2 register form: R0 = R0 + R1 + cy
    send('h3D, 0, "R10"); send('h51, 0, "R4"); idle_sweep("R2");
    // R5 set-both: R2 = R2 + R3 + cy
    send('h22, 0, "R5"); send('h3D, 0, "R5"); send('h53, 0, "R5"); idle_sweep("R5");
    // R7 prefixes cleared: back to R0
    send('h3D, 0, "R7"); send('h52, 0, "R7"); idle_sweep("R7");
    // R3 immediate forms
    send('h3F, 1, "R3"); send('h59, 1, "R3"); idle_sweep("R3");
    send('hB3, 1, "R5"); send('h3F, 1, "R3"); send('h55, 1, "R3"); idle_sweep("R3");
    send('h3F, 0, "R3"); send('h5A, 0, "R3"); idle_sweep("R3");
    // R6 carry and overflow: R8 = 0x8888 + 0x8888
    send('h28, 1, "R6"); send('h3D, 1, "R6"); send('h58, 1, "R6"); idle_sweep("R6");
    // clear carry by a small add, then R6 zero: R15 = 0xFFFF + 1 + 0
    send('h3F, 0, "R6"); send('h50, 0, "R6"); idle_sweep("R6");
    send('h2F, 0, "R6"); send('h3F, 0, "R6"); send('h51, 0, "R6"); idle_sweep("R6");
    // R5 destination-only and chains, latest wins
    send('h14, 0, "R5"); send('h3D, 0, "R5"); send('h51, 0, "R5"); idle_sweep("R5");
    send('h25, 0, "R5"); send('hB6, 0, "R5"); send('h17, 0, "R5");
    send('h3D, 0, "R5"); send('h51, 0, "R5"); idle_sweep("R5");
    // R9 bytes during busy window are dropped
    send('h3D, 0, "R9"); send('h52, 0, "R9");
    send('h29, 0, "R9"); send('h3F, 0, "R9"); send('h53, 0, "R9");
    send('hB4, 0, "R9"); send('h3D, 0, "R9"); send('h51, 0, "R9");
    idle_sweep("R9");
    // R10 mode override, R11 ignored bytes
    send('h52, 0, "R11"); send('h00, 0, "R11"); send('hFF, 0, "R11");
    send('h3E, 0, "R10"); send('h55, 0, "R11"); send('h3F, 0, "R10");
    send('h23, 0, "R10"); send('h3D, 0, "R10"); send('h57, 1, "R10"); idle_sweep("R11");

    // weighted random stream
    for (int n = 0; n < 3000; n++) begin
      int r, b;
      r = $urandom_range(0, 9);
      case (r)
        0, 1: b = 'h3D;
        2:    b = 'h3F;
        3:    b = 'h3E;
        4:    b = 'h20 | $urandom_range(0, 15);
        5:    b = 'hB0 | $urandom_range(0, 15);
        6:    b = 'h10 | $urandom_range(0, 15);
        7, 8: b = 'h50 | $urandom_range(0, 15);
        default: b = $urandom_range(0, 255);
      endcase
      step(1'($urandom_range(0, 3) != 0), b, 1'($urandom_range(0, 1)), "R2");
    end
    idle_sweep("R2");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule